// File: doc/BRIEF.md
# ALU Condition Code Register

This block is the flag register that sits beside a narrow ALU. It keeps eight bits: five arithmetic flags (carry/borrow, signed overflow, zero, negative and nibble half-carry) and three control bits (stop disable, the high-priority interrupt mask and the ordinary interrupt mask). When the ALU reports an add, add-with-carry, subtract, subtract-with-borrow or logical operation, the block computes the flags from the operands itself. For a logical operation it takes them from the logical result. The new flags land in the register at the next clock edge.

Software may load the whole register in one write. The high-priority interrupt mask is treated differently from the other bits. A write can clear it but can never set it again. Only a hardware entry into a high-priority interrupt can return it to 1. Dedicated set and clear strobes control the ordinary interrupt mask, and either interrupt entry sets that mask. The outputs are the register value, the two mask levels and a stop-enable level.

Top module: `ccr_unit`

## Requirements
- R1: While reset is asserted and right after it, the register reads 0xD0. Bit order from MSB to LSB is S(7), X(6), H(5), I(4), N(3), Z(2), V(1), C(0), so S, X and I are 1 and every arithmetic flag is 0.
- R2: ADD (alu_op=1) computes op_a+op_b. C is the carry out of bit 7, V is two's-complement overflow, Z is set for a zero result, N copies result bit 7, and H is the carry out of bit 3 into bit 4.
- R3: SUB (alu_op=3) computes op_a-op_b. C is the borrow out of bit 7, V = (a7&~b7&~r7)|(~a7&b7&r7), Z and N follow the result, and H is left unchanged.
- R4: A logical operation (alu_op=5) sets N and Z from logic_res and clears V. It leaves C and H unchanged.
- R5: A write (wr_en=1) loads every bit from wr_data except X, which may only go from 1 to 0.
- R6: A write that tries to set X while X is 0 leaves X at 0. A pri_irq_entry pulse sets both X and I.
- R7: set_imask sets I, clr_imask clears I, and an irq_entry pulse sets I.
- R8: irq_masked equals I, pri_irq_masked equals X, and stop_enable is the inverse of S.
- R9: In a single cycle, a write takes precedence over an ALU flag update. For I the priority is interrupt entry, then set_imask, then clr_imask, then the write. pri_irq_entry takes precedence over a write for X.
- R10: With alu_op=0 and no write, strobe or entry, the register holds its value whatever the operand inputs do.
- R11: ADC (alu_op=2) adds the current C as carry-in, and SBC (alu_op=4) subtracts the current C as borrow-in. Their flags follow R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_op | input | 3 | 0 none, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 logical |
| op_a | input | 8 | First ALU operand |
| op_b | input | 8 | Second ALU operand |
| logic_res | input | 8 | Result of a logical ALU operation |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| set_imask | input | 1 | Set I |
| clr_imask | input | 1 | Clear I |
| irq_entry | input | 1 | Ordinary interrupt entry, sets I |
| pri_irq_entry | input | 1 | High-priority interrupt entry, sets X and I |
| ccr_q | output | 8 | Register value |
| irq_masked | output | 1 | I bit |
| pri_irq_masked | output | 1 | X bit |
| stop_enable | output | 1 | Inverse of S |

## Verification
The directed tests first target the half-carry boundary at 0x0F+0x01. A design that takes the carry from the wrong bit leaves H at 0 there. The tests then cover the signed limits 0x7F+0x01 and 0x80-0x01, where an inverted overflow term gives a wrong V, and a borrow from 0x00-0x01, where reporting carry instead of borrow leaves C clear. ADC and SBC run with C already set, which shows whether the carry-in is really used. A write of 0xFF after X has been cleared must read back 0xBF, and a design that treats X like any other bit would show 0xFF. Same-cycle collisions of a write with an ALU update, with set_imask and with pri_irq_entry expose an arbitration order that is wrong.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned CCR_W = 8;

  // bit positions inside the register (software sees this layout)
  localparam int unsigned BIT_C = 0;
  localparam int unsigned BIT_V = 1;
  localparam int unsigned BIT_Z = 2;
  localparam int unsigned BIT_N = 3;
  localparam int unsigned BIT_I = 4;
  localparam int unsigned BIT_H = 5;
  localparam int unsigned BIT_X = 6;
  localparam int unsigned BIT_S = 7;

  localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADC   = 3'd2,
    OP_SUB   = 3'd3,
    OP_SBC   = 3'd4,
    OP_LOGIC = 3'd5
  } alu_op_e;

  // arithmetic flag values plus per-flag update enables
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic h;
    logic en_nz;
    logic en_v;
    logic en_c;
    logic en_h;
  } flag_upd_t;

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] logic_res,
  input  logic              carry_in,
  output flag_upd_t         upd
);

  localparam int unsigned MSB    = DATA_W - 1;
  localparam int unsigned NIB_W  = 4;

  // full-width sum with carry out in the top bit
  function automatic logic [DATA_W:0] add_ext(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  // full-width difference; top bit is the borrow out
  function automatic logic [DATA_W:0] sub_ext(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic bin);
    return {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
  endfunction

  // carry out of the low nibble
  function automatic logic nib_carry(input logic [NIB_W-1:0] a,
                                     input logic [NIB_W-1:0] b,
                                     input logic cin);
    logic [NIB_W:0] t;
    t = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
    return t[NIB_W];
  endfunction

  function automatic logic add_ovf(input logic a7, input logic b7, input logic r7);
    return (a7 & b7 & ~r7) | (~a7 & ~b7 & r7);
  endfunction

  function automatic logic sub_ovf(input logic a7, input logic b7, input logic r7);
    return (a7 & ~b7 & ~r7) | (~a7 & b7 & r7);
  endfunction

  logic              use_cin;
  logic [DATA_W:0]   add_r;
  logic [DATA_W:0]   sub_r;
  logic              add_h;

  assign use_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
  assign add_r   = add_ext(op_a, op_b, use_cin);
  assign sub_r   = sub_ext(op_a, op_b, use_cin);
  assign add_h   = nib_carry(op_a[NIB_W-1:0], op_b[NIB_W-1:0], use_cin);

  always_comb begin
    upd = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        upd.n     = add_r[MSB];
        upd.z     = (add_r[MSB:0] == '0);
        upd.v     = add_ovf(op_a[MSB], op_b[MSB], add_r[MSB]);
        upd.c     = add_r[DATA_W];
        upd.h     = add_h;
        upd.en_nz = 1'b1;
        upd.en_v  = 1'b1;
        upd.en_c  = 1'b1;
        upd.en_h  = 1'b1;
      end
      OP_SUB, OP_SBC: begin
        upd.n     = sub_r[MSB];
        upd.z     = (sub_r[MSB:0] == '0);
        upd.v     = sub_ovf(op_a[MSB], op_b[MSB], sub_r[MSB]);
        upd.c     = sub_r[DATA_W];
        upd.en_nz = 1'b1;
        upd.en_v  = 1'b1;
        upd.en_c  = 1'b1;
      end
      OP_LOGIC: begin
        upd.n     = logic_res[MSB];
        upd.z     = (logic_res == '0);
        upd.v     = 1'b0;
        upd.en_nz = 1'b1;
        upd.en_v  = 1'b1;
      end
      default: upd = '0;
    endcase
  end

endmodule

// File: rtl/ccr_sw_filter.sv
module ccr_sw_filter
  import ccr_pkg::*;
(
  input  logic [CCR_W-1:0] cur,
  input  logic [CCR_W-1:0] wr_data,
  output logic [CCR_W-1:0] filtered,
  output logic             x_blocked
);

  // X may only be cleared by a write; every other bit loads directly
  for (genvar b = 0; b < CCR_W; b++) begin : g_bit
    if (b == BIT_X) begin : g_clear_only
      assign filtered[b] = cur[b] & wr_data[b];
    end else begin : g_plain
      assign filtered[b] = wr_data[b];
    end
  end

  assign x_blocked = ~cur[BIT_X] & wr_data[BIT_X];

endmodule

// File: rtl/ccr_mask_ctl.sv
module ccr_mask_ctl (
  input  logic i_base,
  input  logic x_base,
  input  logic set_imask,
  input  logic clr_imask,
  input  logic irq_entry,
  input  logic pri_irq_entry,
  output logic i_next,
  output logic x_next,
  output logic x_raise
);

  logic any_entry;

  assign any_entry = irq_entry | pri_irq_entry;
  assign x_raise   = pri_irq_entry;

  // I priority: entry, set strobe, clear strobe, then the write/held value
  always_comb begin
    if (any_entry)      i_next = 1'b1;
    else if (set_imask) i_next = 1'b1;
    else if (clr_imask) i_next = 1'b0;
    else                i_next = i_base;
  end

  assign x_next = pri_irq_entry ? 1'b1 : x_base;

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        alu_op,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] logic_res,
  input  logic              wr_en,
  input  logic [CCR_W-1:0]  wr_data,
  input  logic              set_imask,
  input  logic              clr_imask,
  input  logic              irq_entry,
  input  logic              pri_irq_entry,
  output logic [CCR_W-1:0]  ccr_q,
  output logic              irq_masked,
  output logic              pri_irq_masked,
  output logic              stop_enable
);

  flag_upd_t        upd;
  logic [CCR_W-1:0] wr_filtered;
  logic [CCR_W-1:0] base;
  logic [CCR_W-1:0] ccr_d;
  logic             i_next;
  logic             x_next;

  // named events for the checker
  logic             alu_upd_en;
  logic             x_write_blocked;
  logic             x_raise;
  logic             x_block_raw;

  ccr_flag_calc #(.DATA_W(DATA_W)) u_flags (
    .op        (alu_op_e'(alu_op)),
    .op_a      (op_a),
    .op_b      (op_b),
    .logic_res (logic_res),
    .carry_in  (ccr_q[BIT_C]),
    .upd       (upd)
  );

  ccr_sw_filter u_filter (
    .cur       (ccr_q),
    .wr_data   (wr_data),
    .filtered  (wr_filtered),
    .x_blocked (x_block_raw)
  );

  assign alu_upd_en      = upd.en_nz;
  assign x_write_blocked = wr_en & x_block_raw;

  always_comb begin
    base = ccr_q;
    if (upd.en_nz) begin
      base[BIT_N] = upd.n;
      base[BIT_Z] = upd.z;
    end
    if (upd.en_v) base[BIT_V] = upd.v;
    if (upd.en_c) base[BIT_C] = upd.c;
    if (upd.en_h) base[BIT_H] = upd.h;
    if (wr_en)    base        = wr_filtered;
  end

  ccr_mask_ctl u_masks (
    .i_base        (base[BIT_I]),
    .x_base        (base[BIT_X]),
    .set_imask     (set_imask),
    .clr_imask     (clr_imask),
    .irq_entry     (irq_entry),
    .pri_irq_entry (pri_irq_entry),
    .i_next        (i_next),
    .x_next        (x_next),
    .x_raise       (x_raise)
  );

  always_comb begin
    ccr_d        = base;
    ccr_d[BIT_I] = i_next;
    ccr_d[BIT_X] = x_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr_q <= CCR_RESET;
    else        ccr_q <= ccr_d;
  end

  assign irq_masked     = ccr_q[BIT_I];
  assign pri_irq_masked = ccr_q[BIT_X];
  assign stop_enable    = ~ccr_q[BIT_S];

endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        alu_op,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] logic_res,
  input logic              wr_en,
  input logic [CCR_W-1:0]  wr_data,
  input logic              set_imask,
  input logic              clr_imask,
  input logic              irq_entry,
  input logic              pri_irq_entry,
  input logic [CCR_W-1:0]  ccr_q,
  input logic              irq_masked,
  input logic              pri_irq_masked,
  input logic              stop_enable,
  input logic              alu_upd_en,
  input logic              x_write_blocked,
  input logic              x_raise
);

  logic [DATA_W-1:0] chk_sum;
  logic              no_ctl;

  assign chk_sum = op_a + op_b;
  assign no_ctl  = !wr_en && !set_imask && !clr_imask && !irq_entry && !pri_irq_entry;

  // R1/R8: output levels follow the register bits
  a_r8_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_masked == ccr_q[BIT_I]) && (pri_irq_masked == ccr_q[BIT_X]) && (stop_enable != ccr_q[BIT_S]));

  // R2: plain add zero flag
  a_r2_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd1 && no_ctl) |=> (ccr_q[BIT_Z] == ($past(chk_sum) == '0)));

  // R4: logical op clears V and keeps C, Z follows logic_res
  a_r4_logic: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd5 && no_ctl) |=>
      (!ccr_q[BIT_V] && ccr_q[BIT_C] == $past(ccr_q[BIT_C]) && ccr_q[BIT_Z] == ($past(logic_res) == '0)));

  // R5: a lone write loads every bit except X
  a_r5_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_imask && !clr_imask && !irq_entry && !pri_irq_entry) |=>
      ({ccr_q[7], ccr_q[5:0]} == {$past(wr_data[7]), $past(wr_data[5:0])}));

  // R6: X stays 0 without a high-priority entry
  a_r6_x_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_irq_masked && !pri_irq_entry) |=> !pri_irq_masked);

  // R6: blocked write leaves X clear
  a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (x_write_blocked && !pri_irq_entry) |=> !pri_irq_masked);

  // R6: entry raises both masks
  a_r6_entry: assert property (@(posedge clk) disable iff (!rst_n)
    x_raise |=> (pri_irq_masked && irq_masked));

  // R7: clear strobe alone drops I
  a_r7_cli: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_imask && !set_imask && !irq_entry && !pri_irq_entry) |=> !irq_masked);

  // R10: nothing active holds the register
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_upd_en && no_ctl) |=> $stable(ccr_q));

endmodule

bind ccr_unit ccr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .alu_op          (alu_op),
  .op_a            (op_a),
  .op_b            (op_b),
  .logic_res       (logic_res),
  .wr_en           (wr_en),
  .wr_data         (wr_data),
  .set_imask       (set_imask),
  .clr_imask       (clr_imask),
  .irq_entry       (irq_entry),
  .pri_irq_entry   (pri_irq_entry),
  .ccr_q           (ccr_q),
  .irq_masked      (irq_masked),
  .pri_irq_masked  (pri_irq_masked),
  .stop_enable     (stop_enable),
  .alu_upd_en      (alu_upd_en),
  .x_write_blocked (x_write_blocked),
  .x_raise         (x_raise)
);

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] alu_op = 3'd0;
  logic [7:0] op_a = 8'h00;
  logic [7:0] op_b = 8'h00;
  logic [7:0] logic_res = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       set_imask = 1'b0;
  logic       clr_imask = 1'b0;
  logic       irq_entry = 1'b0;
  logic       pri_irq_entry = 1'b0;
  logic [7:0] ccr_q;
  logic       irq_masked;
  logic       pri_irq_masked;
  logic       stop_enable;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_ccr = 8'hD0;

  always #10 clk = ~clk;

  ccr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .op_a(op_a), .op_b(op_b),
    .logic_res(logic_res), .wr_en(wr_en), .wr_data(wr_data),
    .set_imask(set_imask), .clr_imask(clr_imask), .irq_entry(irq_entry),
    .pri_irq_entry(pri_irq_entry), .ccr_q(ccr_q), .irq_masked(irq_masked),
    .pri_irq_masked(pri_irq_masked), .stop_enable(stop_enable)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk8(tag, ccr_q, exp_ccr);
    chk8({tag, " R8 levels"}, {5'd0, irq_masked, pri_irq_masked, stop_enable},
         {5'd0, exp_ccr[4], exp_ccr[6], ~exp_ccr[7]});
  endtask

  task automatic idle_inputs();
    alu_op = 3'd0; wr_en = 1'b0; set_imask = 1'b0; clr_imask = 1'b0;
    irq_entry = 1'b0; pri_irq_entry = 1'b0;
  endtask

  // inputs already driven at a negedge; clock once and check
  task automatic clock_and_check(input string tag);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk_all(tag);
  endtask

  function automatic int sgn(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  task automatic arith(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input string tag);
    int cin, ur, sr, res;
    bit is_add;
    is_add = (op == 3'd1) || (op == 3'd2);
    cin = ((op == 3'd2) || (op == 3'd4)) ? int'(exp_ccr[0]) : 0;
    if (is_add) begin
      ur = int'(a) + int'(b) + cin;
      sr = sgn(a) + sgn(b) + cin;
      exp_ccr[0] = (ur > 255);
      exp_ccr[5] = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
      res = ur % 256;
    end else begin
      ur = int'(a) - int'(b) - cin;
      sr = sgn(a) - sgn(b) - cin;
      exp_ccr[0] = (ur < 0);
      res = (ur + 256) % 256;
    end
    exp_ccr[1] = (sr > 127) || (sr < -128);
    exp_ccr[2] = (res == 0);
    exp_ccr[3] = (res >= 128);
    alu_op = op; op_a = a; op_b = b;
    clock_and_check(tag);
  endtask

  task automatic logic_op(input logic [7:0] r, input string tag);
    exp_ccr[3] = r[7];
    exp_ccr[2] = (r == 8'h00);
    exp_ccr[1] = 1'b0;
    alu_op = 3'd5; logic_res = r; op_a = ~r; op_b = r;
    clock_and_check(tag);
  endtask

  task automatic sw_write(input logic [7:0] d, input string tag);
    exp_ccr = {d[7], exp_ccr[6] & d[6], d[5:0]};
    wr_en = 1'b1; wr_data = d;
    clock_and_check(tag);
  endtask

  task automatic t_reset();
    chk_all("R1 reset value during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_all("R1 reset value after release");
  endtask

  task automatic t_add();
    arith(3'd1, 8'h0F, 8'h01, "R2 half-carry 0F+01");
    arith(3'd1, 8'h80, 8'h80, "R2 carry overflow zero 80+80");
    arith(3'd2, 8'hFF, 8'h00, "R11 ADC with C=1");
    arith(3'd1, 8'h7F, 8'h01, "R2 signed overflow 7F+01");
    arith(3'd2, 8'h12, 8'h34, "R11 ADC with C=0");
  endtask

  task automatic t_sub();
    arith(3'd1, 8'h08, 8'h08, "R2 set H before sub");
    arith(3'd3, 8'h00, 8'h01, "R3 borrow 00-01 keeps H");
    arith(3'd4, 8'h10, 8'h0F, "R11 SBC with C=1");
    arith(3'd3, 8'h80, 8'h01, "R3 signed overflow 80-01");
    arith(3'd3, 8'h05, 8'h05, "R3 zero 05-05");
    arith(3'd3, 8'h7F, 8'hFF, "R3 overflow 7F-FF");
  endtask

  task automatic t_logic();
    arith(3'd1, 8'hFF, 8'h01, "R2 prepare C and H");
    arith(3'd3, 8'h80, 8'h01, "R3 prepare V");
    logic_op(8'h00, "R4 logic zero clears V");
    logic_op(8'h90, "R4 logic negative");
  endtask

  task automatic t_write();
    sw_write(8'h2F, "R5 write clears X");
    sw_write(8'hFF, "R6 write cannot set X");
    pri_irq_entry = 1'b1;
    exp_ccr[6] = 1'b1; exp_ccr[4] = 1'b1;
    clock_and_check("R6 entry sets X and I");
    sw_write(8'h4A, "R5 write with X kept");
  endtask

  task automatic t_imask();
    clr_imask = 1'b1; exp_ccr[4] = 1'b0;
    clock_and_check("R7 clear I");
    set_imask = 1'b1; exp_ccr[4] = 1'b1;
    clock_and_check("R7 set I");
    clr_imask = 1'b1; exp_ccr[4] = 1'b0;
    clock_and_check("R7 clear I again");
    irq_entry = 1'b1; exp_ccr[4] = 1'b1;
    clock_and_check("R7 irq entry sets I");
  endtask

  task automatic t_priority();
    wr_en = 1'b1; wr_data = 8'h00; alu_op = 3'd1; op_a = 8'h0F; op_b = 8'h01;
    exp_ccr = {1'b0, exp_ccr[6] & 1'b0, 6'h00};
    clock_and_check("R9 write beats ALU update");
    wr_en = 1'b1; wr_data = 8'h00; set_imask = 1'b1;
    exp_ccr = 8'h10;
    clock_and_check("R9 set strobe beats write");
    wr_en = 1'b1; wr_data = 8'h10; clr_imask = 1'b1;
    exp_ccr = 8'h00;
    clock_and_check("R9 clear strobe beats write");
    clr_imask = 1'b1; irq_entry = 1'b1;
    exp_ccr = 8'h10;
    clock_and_check("R9 entry beats clear strobe");
    wr_en = 1'b1; wr_data = 8'hAF; pri_irq_entry = 1'b1;
    exp_ccr = 8'hFF;
    clock_and_check("R9 priority entry beats write for X");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++) begin
      op_a = 8'h11 * k[7:0]; op_b = ~op_a; logic_res = 8'h00;
      clock_and_check("R10 idle holds");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_write();
    t_imask();
    t_priority();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule